// File: doc/BRIEF.md
# Serial Channel-Select Address Register

This block is the digital front end of a sixteen-way channel selector that is programmed over a mode 0 SPI link. The master frames a command by pulling the active-low select line low. It then clocks eight bits into an internal shift register, most significant bit first. The low four bits of the register are the channel number. The selector only sees a new channel when the select line returns high. Until then the previously committed channel stays in force, so a half-written command never reaches the switch fabric.

All three serial inputs are oversampled by the much faster system clock through two-flop synchronizers, and edges are found in that domain. While a frame is open, the register's previous contents leave on MISO, most significant bit first. The first bit is valid before the first SCLK edge, so several devices can be chained. Every frame end produces a one-cycle commit strobe that carries the address to the downstream channel selector. A frame whose length is not eight clocks still commits its low nibble and raises an error flag with the strobe.

Top module: `spi_addr_reg`

## Requirements
- R1: While rst_n is low at a rising clk edge, the shift register and sel_addr clear to zero, commit_vld and frame_err stay low, and miso_oe is low; the first frame after reset therefore shifts out eight zero bits.
- R2: Each rising SCLK edge seen while ss_n is low shifts mosi into bit 0 of the 8-bit register, moving the older bits toward bit 7. After eight edges, bits 3..0 hold the channel address; for example, the frame 0000_1001 gives address 9. Bits 7..4 never affect the address.
- R3: sel_addr holds its value for the whole frame and changes only in the cycle where a rising edge of ss_n is recognised.
- R4: Each rising edge of ss_n produces exactly one single-cycle commit_vld pulse. During that pulse, commit_addr carries the committed address.
- R5: frame_err is high during the commit_vld cycle exactly when the frame had a number of SCLK rising edges other than eight (including zero), and the low nibble is committed anyway.
- R6: Once ss_n falls, miso carries bit 7 of the register before the first SCLK edge, and each SCLK falling edge inside the frame puts the next older bit on miso.
- R7: A frame longer than eight clocks returns on miso, from its ninth bit period on, the bits that entered mosi eight clocks earlier, in the same order.
- R8: miso_oe is high while the synchronised ss_n is low and low while it is high.
- R9: SCLK and mosi activity while ss_n is high leaves the shift register unchanged.
- R10: When the last SCLK rising edge and the ss_n rising edge are recognised in the same system cycle, that bit is still shifted in, counted in the frame length and included in the committed address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, idle low |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low frame select |
| miso | output | 1 | Serial data to the master or the next device in the chain |
| miso_oe | output | 1 | Output enable for the miso pad driver |
| sel_addr | output | 4 | Committed channel address held for the selector |
| commit_vld | output | 1 | One-cycle strobe at frame end |
| commit_addr | output | 4 | Address delivered with the strobe |
| frame_err | output | 1 | Frame length was not eight, valid with the strobe |

## Verification
The final SCLK rising edge and the ss_n rising edge can be recognised in the same system cycle. The shift path and the commit path then act together, and the commit must see the register and the bit count with that last bit already included. The bench provokes this by raising sclk and ss_n in the same simulation step on the last bit of a frame. It checks the strobe's address and error flag against a bench model that counts that bit. Neighbouring frames with a normal trailing low phase, and frames that are one bit short or one bit long, confirm that the counting is otherwise unchanged.

// File: rtl/spi_addr_pkg.sv
// Package: shared widths for the serial channel-select address register.
// Assumes one frame width and one address width for every instance.
package spi_addr_pkg;
    parameter int FRAME_BITS = 8;
    parameter int ADDR_BITS  = 4;
    localparam int CNT_W     = $clog2(FRAME_BITS) + 1;

    typedef logic [FRAME_BITS-1:0] frame_t;
    typedef logic [ADDR_BITS-1:0]  addr_t;
    typedef logic [CNT_W-1:0]      cnt_t;
endpackage

// File: rtl/spi_addr_sync.sv
// Module: multi-bit two-or-more-stage synchroniser for asynchronous inputs.
// Assumes each bit is independent; reset loads the idle level of each line.
module spi_addr_sync #(
    parameter int              WIDTH     = 3,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            // Shift each input bit through its own flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RESET_VAL[b]}};
                else        chain <= {chain[STAGES-2:0], d_in[b]};
            end
            assign d_out[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/spi_addr_edges.sv
// Module: edge finder for the synchronised SCLK and slave-select lines.
// Assumes inputs are already synchronous to clk; pulses last one cycle.
module spi_addr_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic ss_s,
    output logic shift_en,
    output logic miso_step,
    output logic frame_open,
    output logic frame_close,
    output logic sel_active
);
    logic sclk_q;
    logic ss_q;

    // Remember the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            ss_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            ss_q   <= ss_s;
        end
    end

    // A rise accepted while select was low in the previous sample shifts,
    // so a rise that coincides with the closing edge still counts.
    assign shift_en    = sclk_s & ~sclk_q & ~ss_q;
    assign miso_step   = ~sclk_s & sclk_q & ~ss_s;
    assign frame_open  = ~ss_s & ss_q;
    assign frame_close = ss_s & ~ss_q;
    assign sel_active  = ~ss_s;
endmodule

// File: rtl/spi_addr_shift.sv
// Module: frame shift register, bit counter and MISO output stage.
// Assumes edge pulses come from spi_addr_edges; exposes next-state values
// so a commit in the same cycle as the last shift sees that bit.
module spi_addr_shift
    import spi_addr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   mosi_s,
    input  logic   shift_en,
    input  logic   miso_step,
    input  logic   frame_open,
    output frame_t sr_next,
    output cnt_t   cnt_next,
    output logic   miso
);
    localparam cnt_t CNT_MAX = {CNT_W{1'b1}};

    frame_t sr_q;
    cnt_t   cnt_q;
    logic   miso_q;

    // Next register and count values including a shift in this cycle.
    always_comb begin
        cnt_t base;
        base     = frame_open ? '0 : cnt_q;
        sr_next  = shift_en ? {sr_q[FRAME_BITS-2:0], mosi_s} : sr_q;
        cnt_next = (shift_en && base != CNT_MAX) ? base + 1'b1 : base;
    end

    // Update register, counter and the MISO bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            miso_q <= 1'b0;
        end else begin
            sr_q  <= sr_next;
            cnt_q <= cnt_next;
            if (frame_open || miso_step) miso_q <= sr_q[FRAME_BITS-1];
        end
    end

    assign miso = miso_q;
endmodule

// File: rtl/spi_addr_commit.sv
// Module: frame-end commit of the channel address with strobe and error.
// Assumes frame_close is a one-cycle pulse; sr_next/cnt_next include any
// shift recognised in that same cycle.
module spi_addr_commit
    import spi_addr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frame_close,
    input  frame_t sr_next,
    input  cnt_t   cnt_next,
    output addr_t  sel_addr,
    output logic   commit_vld,
    output addr_t  commit_addr,
    output logic   frame_err
);
    localparam cnt_t FULL = cnt_t'(FRAME_BITS);

    // Latch the low nibble and flag a wrong-length frame at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_addr    <= '0;
            commit_vld  <= 1'b0;
            commit_addr <= '0;
            frame_err   <= 1'b0;
        end else begin
            commit_vld <= frame_close;
            frame_err  <= frame_close && (cnt_next != FULL);
            if (frame_close) begin
                sel_addr    <= sr_next[ADDR_BITS-1:0];
                commit_addr <= sr_next[ADDR_BITS-1:0];
            end
        end
    end
endmodule

// File: rtl/spi_addr_reg.sv
// Module: top of the serial channel-select address register.
// Assumes mode 0 SPI and a system clock several times faster than SCLK.
module spi_addr_reg
    import spi_addr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk,
    input  logic                 mosi,
    input  logic                 ss_n,
    output logic                 miso,
    output logic                 miso_oe,
    output logic [ADDR_BITS-1:0] sel_addr,
    output logic                 commit_vld,
    output logic [ADDR_BITS-1:0] commit_addr,
    output logic                 frame_err
);
    logic [2:0] raw_in, syn_in;
    logic       shift_en, miso_step, frame_open, frame_close;
    frame_t     sr_next;
    cnt_t       cnt_next;

    assign raw_in = {ss_n, mosi, sclk};

    spi_addr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(raw_in), .d_out(syn_in)
    );

    spi_addr_edges u_edges (
        .clk(clk), .rst_n(rst_n), .sclk_s(syn_in[0]), .ss_s(syn_in[2]),
        .shift_en(shift_en), .miso_step(miso_step), .frame_open(frame_open),
        .frame_close(frame_close), .sel_active(miso_oe)
    );

    spi_addr_shift u_shift (
        .clk(clk), .rst_n(rst_n), .mosi_s(syn_in[1]), .shift_en(shift_en),
        .miso_step(miso_step), .frame_open(frame_open), .sr_next(sr_next),
        .cnt_next(cnt_next), .miso(miso)
    );

    spi_addr_commit u_commit (
        .clk(clk), .rst_n(rst_n), .frame_close(frame_close), .sr_next(sr_next),
        .cnt_next(cnt_next), .sel_addr(sel_addr), .commit_vld(commit_vld),
        .commit_addr(commit_addr), .frame_err(frame_err)
    );
endmodule

// File: rtl/spi_addr_reg_chk.sv
// Module: property checker bound to spi_addr_reg; observes ports only.
module spi_addr_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ss_n,
    input logic       miso_oe,
    input logic [3:0] sel_addr,
    input logic       commit_vld,
    input logic [3:0] commit_addr,
    input logic       frame_err
);
    // R1: the cycle after a reset edge shows cleared outputs.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (sel_addr == 4'd0 && !commit_vld && !frame_err && !miso_oe));

    // R3: the held address moves only together with a commit.
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_addr) |-> commit_vld);

    // R4: the strobe lasts one cycle and carries the held address.
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit_vld |=> !commit_vld);
    a_r4_strobe_addr: assert property (@(posedge clk) disable iff (!rst_n)
        commit_vld |-> (commit_addr == sel_addr));

    // R5: the error flag appears only with the strobe.
    a_r5_err_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> commit_vld);

    // R8: a select line held high for several cycles disables the driver.
    a_r8_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_n && $past(ss_n) && $past(ss_n, 2) && $past(ss_n, 3)) |-> !miso_oe);
endmodule

bind spi_addr_reg spi_addr_reg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .miso_oe(miso_oe),
    .sel_addr(sel_addr), .commit_vld(commit_vld), .commit_addr(commit_addr),
    .frame_err(frame_err)
);

// File: tb/spi_addr_reg_tb.sv
module spi_addr_reg_tb;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, ss_n = 1'b1;
    logic miso, miso_oe, commit_vld, frame_err;
    logic [3:0] sel_addr, commit_addr;

    int n_checks = 0, n_fail = 0;
    int n_commit = 0;
    logic [3:0] got_addr;
    logic       got_err;
    logic [7:0] model_sr = 8'h00;
    logic [3:0] model_sel = 4'h0;

    always #5 clk = ~clk;

    spi_addr_reg u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
        .miso(miso), .miso_oe(miso_oe), .sel_addr(sel_addr),
        .commit_vld(commit_vld), .commit_addr(commit_addr), .frame_err(frame_err)
    );

    // Capture strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && commit_vld) begin
            n_commit++;
            got_addr = commit_addr;
            got_err  = frame_err;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of nbits, bits taken from data MSB first (bit nbits-1 first).
    // coincide: the last SCLK rise and the select rise happen together.
    task automatic frame(input int nbits, input logic [15:0] data, input bit coincide);
        int start_commit;
        bit miso_ok;
        bit hold_ok;
        logic [3:0] sel_before;
        logic [7:0] exp_sr;
        int first_bad;
        start_commit = n_commit;
        miso_ok = 1;
        hold_ok = 1;
        first_bad = 0;
        sel_before = sel_addr;
        exp_sr = model_sr;
        ss_n = 1'b0;
        wait_clk(HALF);
        check(miso_oe === 1'b1, "R8 oe in frame", miso_oe, 1);
        for (int i = 0; i < nbits; i++) begin
            mosi = data[nbits-1-i];
            wait_clk(HALF);
            if (miso !== exp_sr[7]) begin
                if (miso_ok) first_bad = i;
                miso_ok = 0;
            end
            if (sel_addr !== sel_before) hold_ok = 0;
            exp_sr = {exp_sr[6:0], data[nbits-1-i]};
            sclk = 1'b1;
            if (coincide && i == nbits - 1) begin
                ss_n = 1'b1;
                wait_clk(HALF);
                sclk = 1'b0;
            end else begin
                wait_clk(HALF);
                sclk = 1'b0;
            end
        end
        if (!coincide || nbits == 0) begin
            wait_clk(HALF);
            if (sel_addr !== sel_before) hold_ok = 0;
            ss_n = 1'b1;
        end
        wait_clk(8);
        model_sr = exp_sr;
        model_sel = exp_sr[3:0];
        check(miso_ok, "R6/R7 miso sequence", first_bad, 0);
        check(hold_ok, "R3 address held during frame", sel_addr, sel_before);
        check(n_commit == start_commit + 1, "R4 one strobe per frame", n_commit - start_commit, 1);
        check(got_addr == model_sel, coincide ? "R10 coincident commit addr" : "R2 commit addr",
              got_addr, model_sel);
        check(got_err == (nbits != 8), "R5 frame_err", got_err, nbits != 8);
        check(sel_addr == model_sel, "R3 sel_addr after close", sel_addr, model_sel);
        check(miso_oe === 1'b0, "R8 oe idle", miso_oe, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        wait_clk(4);
        // R1 reset state.
        check(sel_addr == 4'd0, "R1 sel_addr reset", sel_addr, 0);
        check(commit_vld == 1'b0, "R1 strobe reset", commit_vld, 0);
        check(miso_oe == 1'b0, "R1 oe reset", miso_oe, 0);
        rst_n = 1'b1;
        wait_clk(4);
        check(n_commit == 0, "R1 no strobe after reset", n_commit, 0);

        // R2 example frame selects channel 9; R1 first frame returns zeros.
        frame(8, 16'h0009, 0);
        // R2 upper nibble ignored.
        frame(8, 16'h00F3, 0);
        // R9 SCLK and mosi toggling with select high.
        for (int k = 0; k < 5; k++) begin
            mosi = k[0];
            sclk = 1'b1; wait_clk(HALF);
            sclk = 1'b0; wait_clk(HALF);
        end
        check(n_commit == 2, "R9 no strobe while idle", n_commit, 2);
        frame(8, 16'h00A5, 0);   // its miso checks model unchanged by R9 toggles
        // R5 short, empty and long frames.
        frame(7, 16'h0055, 0);
        frame(0, 16'h0000, 0);
        frame(9, 16'h01C7, 0);
        // R7 long frame returns its own early bits.
        frame(12, 16'h0ABC, 0);
        // R10 coincident last rise and select rise, normal and short lengths.
        frame(8, 16'h006E, 1);
        frame(7, 16'h0021, 1);
        frame(9, 16'h0134, 1);
        // Random frames.
        for (int f = 0; f < 24; f++) begin
            int nb;
            nb = ($urandom % 4 == 0) ? int'($urandom % 13) : 8;
            frame(nb, 16'($urandom), ($urandom % 3) == 0);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule